// File: doc/BRIEF.md
# UART Interrupt Prioritizer with Receive Timeout

This block merges the interrupt causes of a UART into one request line and a small identification code. Software reads the code to find which condition to service first. The causes are a line status error, received data ready, a receive timeout, transmitter empty and a modem status change. The block does not contain the receive FIFO, the shift registers or the modem change detection. It takes their status as inputs: the FIFO fill count, the trigger level, FIFO read and write strobes, a per-sample baud tick, register access strobes and error or change pulses.

Three of the causes are held in sticky flags that are set by an event and cleared by a register access. Data ready is a level that is derived each cycle from the FIFO count. The receive timeout has its own timer, counted in sample ticks. The timer fires when a FIFO holding fewer bytes than the trigger level has had no reads or writes for four character times. A timeout that has fired stays pending until the FIFO has been drained completely, even if new data arrives in the meantime.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After reset `irq` is 0 and `irqId` is 4'b0001, because every sticky flag and the timeout timer start cleared.
- R2: A cycle with `lineErr` high sets the line status flag, and a cycle with `lsrRead` high and `lineErr` low clears it. If both are high in the same cycle, the set wins. When the flag is pending and `enLine` is high, `irqId` is 4'b0110 on the following cycle.
- R3: Data ready is pending when `fifoCount >= trigLevel` with `fifoEn` high, or when `fifoCount != 0` with `fifoEn` low. It reports as 4'b0100 in the same cycle. Reading the FIFO (`fifoRd`) lowers the count, and that is how data ready clears.
- R4: With `fifoEn` high and `0 < fifoCount < trigLevel`, the timer counts `sampleTick` cycles. Any cycle with `fifoRd` or `fifoWr` high restarts the timer from zero. The timeout becomes pending on the 640th counted tick, which is 4 characters × 10 bits × 16 ticks, and it reports as 4'b1100.
- R5: A pending timeout stays pending while `fifoCount` is nonzero, including after the count reaches the trigger level. It clears on the clock edge that sees `fifoCount == 0` or `fifoEn` low.
- R6: `enRx` is a single enable that gates both data ready and timeout.
- R7: A rising edge on `txEmpty` sets the transmit flag, and `thrWrite` clears it, with the clear winning. When the flag is pending and `enTx` is high, it reports as 4'b0010.
- R8: A cycle with `modemChg` high sets the modem flag, and a cycle with `msrRead` high and `modemChg` low clears it. When the flag is pending and `enModem` is high, it reports as 4'b0000.
- R9: When several enabled causes are pending, `irqId` names the first one in this order: line status, data ready, timeout, transmit, modem.
- R10: `irq` is high exactly when some enabled cause is pending. `irqId[0]` is the inverse of `irq`, and `irqId` is 4'b0001 when nothing is pending.
- R11: Clearing an enable hides its cause but does not clear the sticky flag. When the enable is set again, the cause reappears without a new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoEn | input | 1 | Receive FIFO mode enabled |
| fifoCount | input | CNT_W | Bytes held in the receive FIFO |
| trigLevel | input | CNT_W | Receive trigger level |
| fifoRd | input | 1 | Receive FIFO read strobe (receive buffer read) |
| fifoWr | input | 1 | Receive FIFO write strobe |
| sampleTick | input | 1 | One baud sample period elapsed |
| txEmpty | input | 1 | No data waiting to transmit |
| thrWrite | input | 1 | Transmit holding register written |
| lineErr | input | 1 | Parity, framing, overrun or break detected |
| lsrRead | input | 1 | Line status register read |
| modemChg | input | 1 | Modem status input changed |
| msrRead | input | 1 | Modem status register read |
| enTx | input | 1 | Transmit interrupt enable |
| enRx | input | 1 | Data ready and timeout enable |
| enLine | input | 1 | Line status interrupt enable |
| enModem | input | 1 | Modem interrupt enable |
| irq | output | 1 | Interrupt request |
| irqId | output | 4 | Highest-priority pending cause |

## Verification
The assertions check several relations on every cycle: the set and clear effects of the register access strobes, that an empty FIFO suppresses the timeout code on the next cycle, that enabled data ready is reported when line status is disabled, and that the request line agrees with bit 0 of the code. Some behaviours need long histories that a simple property cannot express, so only the bench scenarios show them. These are the exact 639-tick and 640-tick boundary, the timer restart on FIFO activity, a timeout that outlives a count rising past the trigger level, and a masked flag that survives until it is re-enabled.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_NONE    = 4'b0001,
    ID_LINE    = 4'b0110,
    ID_RXDATA  = 4'b0100,
    ID_RXTMO   = 4'b1100,
    ID_TXEMPTY = 4'b0010,
    ID_MODEM   = 4'b0000
  } irqId_e;

  localparam int FLG_LINE  = 0;
  localparam int FLG_TX    = 1;
  localparam int FLG_MODEM = 2;
  localparam int NUM_FLG   = 3;

  typedef struct packed {
    logic [NUM_FLG-1:0] setVec;
    logic [NUM_FLG-1:0] clrVec;
    logic               timerClr;
    logic               timerArm;
    logic               timerTick;
    logic               tmoClr;
    logic               rxReady;
  } irqStrobe_t;

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic             fifoRd,
  input  logic             fifoWr,
  input  logic             sampleTick,
  input  logic             txEmpty,
  input  logic             thrWrite,
  input  logic             lineErr,
  input  logic             lsrRead,
  input  logic             modemChg,
  input  logic             msrRead,
  output irqStrobe_t       strobe
);

  logic txEmptyQ;
  logic countZero;
  logic belowTrig;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txEmptyQ <= 1'b0;
    else       txEmptyQ <= txEmpty;
  end

  assign countZero = (fifoCount == '0);
  assign belowTrig = (fifoCount < trigLevel);

  always_comb begin
    strobe = '0;
    // sticky flag events
    strobe.setVec[FLG_LINE]  = lineErr;
    strobe.clrVec[FLG_LINE]  = lsrRead;
    strobe.setVec[FLG_TX]    = txEmpty && !txEmptyQ;
    strobe.clrVec[FLG_TX]    = thrWrite;
    strobe.setVec[FLG_MODEM] = modemChg;
    strobe.clrVec[FLG_MODEM] = msrRead;
    // receive timeout control
    strobe.timerArm  = fifoEn && !countZero && belowTrig;
    strobe.timerClr  = fifoRd || fifoWr || !strobe.timerArm;
    strobe.timerTick = sampleTick;
    strobe.tmoClr    = !fifoEn || countZero;
    // receive data ready level
    strobe.rxReady   = fifoEn ? !belowTrig : !countZero;
  end

endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int BITS_PER_CHAR = 10,
  parameter int IDLE_CHARS    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  irqStrobe_t strobe,
  input  logic       enTx,
  input  logic       enRx,
  input  logic       enLine,
  input  logic       enModem,
  output logic       irq,
  output logic [3:0] irqId
);

  localparam int LIMIT   = TICKS_PER_BIT * BITS_PER_CHAR * IDLE_CHARS;
  localparam int TIMER_W = $clog2(LIMIT);
  localparam logic [TIMER_W-1:0] LAST = TIMER_W'(LIMIT - 1);

  logic [NUM_FLG-1:0] flag;
  logic [TIMER_W-1:0] timer;
  logic               tmoPend;
  logic               tmoFire;

  // sticky flags: set wins for error and modem, clear wins for transmit
  for (genvar g = 0; g < NUM_FLG; g++) begin : gFlag
    if (g == FLG_TX) begin : gClrWins
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  flag[g] <= 1'b0;
        else if (strobe.clrVec[g])  flag[g] <= 1'b0;
        else if (strobe.setVec[g])  flag[g] <= 1'b1;
      end
    end else begin : gSetWins
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  flag[g] <= 1'b0;
        else if (strobe.setVec[g])  flag[g] <= 1'b1;
        else if (strobe.clrVec[g])  flag[g] <= 1'b0;
      end
    end
  end

  assign tmoFire = strobe.timerArm && !strobe.timerClr &&
                   strobe.timerTick && (timer == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.timerClr) begin
      timer <= '0;
    end else if (strobe.timerTick && timer != LAST) begin
      timer <= timer + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              tmoPend <= 1'b0;
    else if (strobe.tmoClr) tmoPend <= 1'b0;
    else if (tmoFire)       tmoPend <= 1'b1;
  end

  always_comb begin
    irqId = ID_NONE;
    if (enLine && flag[FLG_LINE])         irqId = ID_LINE;
    else if (enRx && strobe.rxReady)      irqId = ID_RXDATA;
    else if (enRx && tmoPend)             irqId = ID_RXTMO;
    else if (enTx && flag[FLG_TX])        irqId = ID_TXEMPTY;
    else if (enModem && flag[FLG_MODEM])  irqId = ID_MODEM;
    irq = !irqId[0];
  end

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
#(
  parameter int CNT_W         = 5,
  parameter int TICKS_PER_BIT = 16,
  parameter int BITS_PER_CHAR = 10,
  parameter int IDLE_CHARS    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [CNT_W-1:0] trigLevel,
  input  logic             fifoRd,
  input  logic             fifoWr,
  input  logic             sampleTick,
  input  logic             txEmpty,
  input  logic             thrWrite,
  input  logic             lineErr,
  input  logic             lsrRead,
  input  logic             modemChg,
  input  logic             msrRead,
  input  logic             enTx,
  input  logic             enRx,
  input  logic             enLine,
  input  logic             enModem,
  output logic             irq,
  output logic [3:0]       irqId
);

  irqStrobe_t strobe;

  uart_irq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .fifoCount(fifoCount),
    .trigLevel(trigLevel), .fifoRd(fifoRd), .fifoWr(fifoWr),
    .sampleTick(sampleTick), .txEmpty(txEmpty), .thrWrite(thrWrite),
    .lineErr(lineErr), .lsrRead(lsrRead), .modemChg(modemChg),
    .msrRead(msrRead), .strobe(strobe)
  );

  uart_irq_datapath #(
    .TICKS_PER_BIT(TICKS_PER_BIT), .BITS_PER_CHAR(BITS_PER_CHAR),
    .IDLE_CHARS(IDLE_CHARS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .enTx(enTx), .enRx(enRx),
    .enLine(enLine), .enModem(enModem), .irq(irq), .irqId(irqId)
  );

endmodule

// File: rtl/uart_irq_checker.sv
module uart_irq_checker
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             fifoEn,
  input logic [CNT_W-1:0] fifoCount,
  input logic [CNT_W-1:0] trigLevel,
  input logic             thrWrite,
  input logic             lineErr,
  input logic             lsrRead,
  input logic             modemChg,
  input logic             msrRead,
  input logic             enTx,
  input logic             enRx,
  input logic             enLine,
  input logic             enModem,
  input logic             irq,
  input logic [3:0]       irqId
);

  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (enLine && lineErr) |=> (irqId == ID_LINE)); // R2

  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRead && !lineErr) |=> (irqId != ID_LINE)); // R2

  AST_RXDATA: assert property (@(posedge clk) disable iff (!rstN)
    (enRx && !enLine && (fifoEn ? (fifoCount >= trigLevel) : (fifoCount != '0)))
      |-> (irqId == ID_RXDATA)); // R3

  AST_TMO_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == '0) |=> (irqId != ID_RXTMO)); // R5

  AST_THR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    thrWrite |=> (irqId != ID_TXEMPTY)); // R7

  AST_MODEM_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (msrRead && !modemChg) |=> (irqId != ID_MODEM)); // R8

  AST_ID_BIT0: assert property (@(posedge clk) disable iff (!rstN)
    (irq == !irqId[0])); // R10

  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (!enTx && !enRx && !enLine && !enModem) |-> !irq); // R11

endmodule

bind uart_irq_arbiter uart_irq_checker #(.CNT_W(CNT_W)) u_checker (
  .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .fifoCount(fifoCount),
  .trigLevel(trigLevel), .thrWrite(thrWrite), .lineErr(lineErr),
  .lsrRead(lsrRead), .modemChg(modemChg), .msrRead(msrRead),
  .enTx(enTx), .enRx(enRx), .enLine(enLine), .enModem(enModem),
  .irq(irq), .irqId(irqId)
);

// File: tb/uart_irq_arbiter_tb.sv
module uart_irq_arbiter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 5;
  localparam int DEPTH      = 16;
  localparam int LIM        = 640;

  localparam logic [3:0] C_NONE = 4'b0001;
  localparam logic [3:0] C_LINE = 4'b0110;
  localparam logic [3:0] C_RDA  = 4'b0100;
  localparam logic [3:0] C_TMO  = 4'b1100;
  localparam logic [3:0] C_TX   = 4'b0010;
  localparam logic [3:0] C_MDM  = 4'b0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEn = 1'b0;
  logic [CNT_W-1:0] fifoCount = '0;
  logic [CNT_W-1:0] trigLevel = 5'd8;
  logic fifoRd = 1'b0, fifoWr = 1'b0, sampleTick = 1'b0;
  logic txEmpty = 1'b0, thrWrite = 1'b0;
  logic lineErr = 1'b0, lsrRead = 1'b0, modemChg = 1'b0, msrRead = 1'b0;
  logic enTx = 1'b0, enRx = 1'b0, enLine = 1'b0, enModem = 1'b0;
  logic irq;
  logic [3:0] irqId;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_arbiter #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .fifoCount(fifoCount),
    .trigLevel(trigLevel), .fifoRd(fifoRd), .fifoWr(fifoWr),
    .sampleTick(sampleTick), .txEmpty(txEmpty), .thrWrite(thrWrite),
    .lineErr(lineErr), .lsrRead(lsrRead), .modemChg(modemChg),
    .msrRead(msrRead), .enTx(enTx), .enRx(enRx), .enLine(enLine),
    .enModem(enModem), .irq(irq), .irqId(irqId)
  );

  // reference state built from the requirements
  logic mTx, mTxQ, mLs, mMd, mTo;
  int   mTim;
  logic mArmed;
  assign mArmed = fifoEn && fifoCount != 0 && fifoCount < trigLevel;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mTx <= 0; mTxQ <= 0; mLs <= 0; mMd <= 0; mTo <= 0; mTim <= 0;
    end else begin
      mTxQ <= txEmpty;
      if (thrWrite) mTx <= 0; else if (txEmpty && !mTxQ) mTx <= 1;
      if (lineErr) mLs <= 1; else if (lsrRead) mLs <= 0;
      if (modemChg) mMd <= 1; else if (msrRead) mMd <= 0;
      if (fifoRd || fifoWr || !mArmed) mTim <= 0;
      else if (sampleTick && mTim != LIM-1) mTim <= mTim + 1;
      if (!fifoEn || fifoCount == 0) mTo <= 0;
      else if (mArmed && !(fifoRd || fifoWr) && sampleTick && mTim == LIM-1) mTo <= 1;
    end
  end

  function automatic logic [3:0] expId();
    logic rda;
    rda = fifoEn ? (fifoCount >= trigLevel) : (fifoCount != 0);
    if (enLine && mLs)   return C_LINE;
    if (enRx && rda)     return C_RDA;
    if (enRx && mTo)     return C_TMO;
    if (enTx && mTx)     return C_TX;
    if (enModem && mMd)  return C_MDM;
    return C_NONE;
  endfunction

  task automatic check(string req, logic [3:0] exp);
    checks++;
    if (irqId !== exp || irq !== !exp[0]) begin
      errors++;
      $display("FAIL %s t=%0t irqId=%b irq=%b expected irqId=%b irq=%b",
               req, $time, irqId, irq, exp, !exp[0]);
    end
  endtask

  // one clock: inputs already set, sample 1 unit after the edge
  task automatic tick1();
    @(posedge clk); #1;
  endtask

  task automatic clrStrobes();
    fifoRd = 0; fifoWr = 0; thrWrite = 0; lineErr = 0; lsrRead = 0;
    modemChg = 0; msrRead = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rstN = 1;
    enTx = 1; enRx = 1; enLine = 1; enModem = 1;
    tick1();
    check("R1", C_NONE);

    // R2 line status
    lineErr = 1; tick1(); lineErr = 0; check("R2 set", C_LINE);
    lsrRead = 1; lineErr = 1; tick1(); lineErr = 0; check("R2 set wins", C_LINE);
    tick1(); lsrRead = 0; check("R2 clear", C_NONE);

    // R7 transmit empty
    txEmpty = 1; tick1(); check("R7 rise", C_TX);
    thrWrite = 1; tick1(); thrWrite = 0; txEmpty = 0; check("R7 clear", C_NONE);
    tick1(); check("R7 no rise", C_NONE);

    // R8 modem
    modemChg = 1; tick1(); modemChg = 0; check("R8 set", C_MDM);
    msrRead = 1; tick1(); msrRead = 0; check("R8 clear", C_NONE);

    // R9 priority stack: modem, tx, line pending
    modemChg = 1; txEmpty = 1; tick1(); modemChg = 0; check("R9 tx over modem", C_TX);
    lineErr = 1; tick1(); lineErr = 0; check("R9 line first", C_LINE);
    fifoCount = 5'd1; tick1(); check("R9 line over rda", C_LINE);
    lsrRead = 1; tick1(); lsrRead = 0; check("R3 nonfifo rda", C_RDA);

    // R11 masking keeps flags
    enRx = 0; enTx = 0; tick1(); check("R11 tx masked", C_MDM);
    enModem = 0; tick1(); check("R11 all masked", C_NONE);
    enTx = 1; tick1(); check("R11 tx returns", C_TX);
    enModem = 1; thrWrite = 1; msrRead = 1; tick1(); clrStrobes(); txEmpty = 0;
    enRx = 1;
    fifoRd = 1; fifoCount = 0; tick1(); fifoRd = 0; check("R3 read clears", C_NONE);

    // R3 / R4 / R5 / R6 FIFO mode
    fifoEn = 1; trigLevel = 5'd8;
    fifoWr = 1; fifoCount = 5'd3; tick1(); fifoWr = 0; check("R3 below trig", C_NONE);
    sampleTick = 1;
    repeat (300) tick1();
    fifoRd = 1; fifoCount = 5'd2; tick1(); fifoRd = 0; // restart
    repeat (639) tick1();
    check("R4 639 ticks", C_NONE);
    tick1(); check("R4 640 ticks", C_TMO);
    enRx = 0; tick1(); check("R6 masked tmo", C_NONE);
    enRx = 1;
    fifoWr = 1; fifoCount = 5'd8; tick1(); fifoWr = 0; check("R3 at trig", C_RDA);
    enRx = 0; tick1(); check("R6 masked rda", C_NONE);
    enRx = 1;
    fifoRd = 1; fifoCount = 5'd2; tick1(); fifoRd = 0; check("R5 stays", C_TMO);
    sampleTick = 0;
    repeat (5) tick1(); check("R5 still", C_TMO);
    fifoRd = 1; fifoCount = 0; tick1(); fifoRd = 0; check("R5 empty clears", C_NONE);

    // gap without ticks does not time out
    fifoWr = 1; fifoCount = 5'd1; tick1(); fifoWr = 0;
    repeat (700) tick1(); check("R4 no ticks", C_NONE);

    // random phase against the reference
    begin
      int cnt;
      void'($urandom(32'h5eed_1234));
      cnt = fifoCount;
      for (int i = 0; i < 20000; i++) begin
        int r;
        clrStrobes();
        r = $urandom % 4000;
        if (r < 2 && cnt < DEPTH) begin fifoWr = 1; cnt++; end
        else if (r < 4 && cnt > 0) begin fifoRd = 1; cnt--; end
        else if (r == 4) begin fifoRd = 1; cnt = 0; end
        fifoCount = CNT_W'(cnt);
        sampleTick = ($urandom % 2) == 0;
        lineErr  = ($urandom % 700) == 0;
        lsrRead  = ($urandom % 300) == 0;
        modemChg = ($urandom % 700) == 0;
        msrRead  = ($urandom % 300) == 0;
        thrWrite = ($urandom % 250) == 0;
        if (($urandom % 200) == 0) txEmpty = !txEmpty;
        if (($urandom % 1500) == 0) enTx = !enTx;
        if (($urandom % 1500) == 0) enRx = !enRx;
        if (($urandom % 1500) == 0) enLine = !enLine;
        if (($urandom % 1500) == 0) enModem = !enModem;
        if (($urandom % 5000) == 0) fifoEn = !fifoEn;
        if (($urandom % 4000) == 0) trigLevel = CNT_W'(1 + $urandom % 14);
        tick1();
        check("R9 random", expId());
        #3;
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule